// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block lets a clocked system read and write one external asynchronous static RAM of 65,536 one-bit words. The host raises a request with a read/write flag, an address and write data. The controller then runs the memory's address, active-low chip enable, active-low write enable and data-out lines through a fixed sequence, and enables its data driver only when that is safe. When the transfer is done it returns a single-cycle acknowledge, and for reads it also returns the sampled data.

Every interval comes from a minimum nanosecond figure, and each figure is a parameter. The figure is divided by the clock period, rounded up, and forced to at least one cycle. Writes are always framed by chip enable. Write enable falls before chip enable falls and rises only after chip enable has risen. The memory's own output buffers therefore stay off for the whole write, and a shared data wire never has two drivers. After a read the controller waits out the memory's output turn-off time before it can drive the wire again.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it is released, chip enable and write enable are high, the data driver is off and acknowledge is low.
- R2: In a write, write enable is low and the data driver is on at least one cycle before chip enable falls, and they stay that way at least one cycle after chip enable rises. The memory holds the written bit when acknowledge appears.
- R3: In a write, chip enable stays low for at least ceil(35 ns / period) cycles, which is 4 at the defaults. The address is set at least one cycle before chip enable falls and does not change until at least one cycle after it rises.
- R4: Write data does not change from one cycle before chip enable falls until one cycle after chip enable rises.
- R5: In a read, chip enable stays low for ceil(55 ns / period) cycles, which is 6 at the defaults. The data-in line is sampled on the clock edge that ends this interval, and that value is presented on rdata together with acknowledge.
- R6: The data driver is never on while chip enable is low with write enable high. After a read's chip enable rises, the driver stays off for at least ceil(35 ns / period) cycles, which is 4 at the defaults.
- R7: Acknowledge is high for exactly one cycle per accepted request. It appears 6 cycles after the accepting edge for a write and 11 cycles after it for a read, at the defaults.
- R8: A request raised while a transfer is in progress is ignored. It produces no acknowledge and no memory access.
- R9: A request held high during the acknowledge cycle is accepted on the next clock edge, so transfers can run back to back with no idle gap beyond that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request; taken on an edge where the controller is idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 1 | Bit to write |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 1 | Bit returned by the last read |
| mem_addr | output | 16 | Address to the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dout | output | 1 | Value driven onto the data wire |
| mem_dq_oe | output | 1 | Data wire driver enable |
| mem_din | input | 1 | Data wire as seen from the memory |

## Verification
The properties assume that the host changes a request's fields only when it is idle. They also assume that the memory answers a read only after its access time has passed since chip enable fell. The stimulus keeps to both conditions. It raises req only at the falling clock edge of an idle or acknowledge cycle. The one exception is a deliberate pulse during a busy transfer. The bench's memory model returns the inverted bit until the access time has elapsed, so a read sampled too early yields the wrong value.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_TURN   = 3'd4
  } strobe_st_t;

  // ceil(ns / period), never less than one cycle
  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/strobe_tick.sv
module strobe_tick #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
  import sram_strobe_pkg::*;
#(
  parameter int CNT_W   = 3,
  parameter int AS_C    = 1,
  parameter int WSTR_C  = 4,
  parameter int WHOLD_C = 1,
  parameter int RSTR_C  = 6,
  parameter int RTURN_C = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_wr,
  input  logic             done,
  output strobe_st_t       st_nxt,
  output logic             op_nxt,
  output logic             accept,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             finish,
  output logic             sample
);

  localparam logic [CNT_W-1:0] LV_AS    = CNT_W'(AS_C - 1);
  localparam logic [CNT_W-1:0] LV_WSTR  = CNT_W'(WSTR_C - 1);
  localparam logic [CNT_W-1:0] LV_WHOLD = CNT_W'(WHOLD_C - 1);
  localparam logic [CNT_W-1:0] LV_RSTR  = CNT_W'(RSTR_C - 1);
  localparam logic [CNT_W-1:0] LV_RTURN = CNT_W'(RTURN_C - 1);

  strobe_st_t st_q;
  logic       op_q;

  always_comb begin
    st_nxt   = st_q;
    accept   = 1'b0;
    load     = 1'b0;
    load_val = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (req) begin
          st_nxt   = ST_SETUP;
          accept   = 1'b1;
          load     = 1'b1;
          load_val = LV_AS;
        end
      end
      ST_SETUP: begin
        if (done) begin
          st_nxt   = ST_STROBE;
          load     = 1'b1;
          load_val = op_q ? LV_WSTR : LV_RSTR;
        end
      end
      ST_STROBE: begin
        if (done) begin
          st_nxt   = op_q ? ST_HOLD : ST_TURN;
          load     = 1'b1;
          load_val = op_q ? LV_WHOLD : LV_RTURN;
        end
      end
      ST_HOLD, ST_TURN: begin
        if (done) st_nxt = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
      op_q <= 1'b0;
    end else begin
      st_q <= st_nxt;
      if (accept) op_q <= req_wr;
    end
  end

  assign op_nxt = accept ? req_wr : op_q;
  assign finish = ((st_q == ST_HOLD) || (st_q == ST_TURN)) && done;
  assign sample = (st_q == ST_STROBE) && done && !op_q;

endmodule

// File: rtl/strobe_pins.sv
module strobe_pins
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_st_t        st_nxt,
  input  logic              op_nxt,
  input  logic              accept,
  input  logic              finish,
  input  logic              sample,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_din,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dq_oe,
  output logic              ack,
  output logic [DATA_W-1:0] rdata
);

  logic wr_busy;

  // write enable and driver cover every non-idle state of a write
  assign wr_busy = op_nxt && (st_nxt != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_dout  <= '0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      ack       <= 1'b0;
      rdata     <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        mem_dout <= req_wdata;
      end
      mem_ce_n  <= (st_nxt != ST_STROBE);
      mem_we_n  <= !wr_busy;
      mem_dq_oe <= wr_busy;
      ack       <= finish;
      if (sample) rdata <= mem_din;
    end
  end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 1,
  parameter int CLK_NS  = 10,
  parameter int T_AS_NS = 5,
  parameter int T_AH_NS = 5,
  parameter int T_CW_NS = 35,
  parameter int T_WC_NS = 55,
  parameter int T_DS_NS = 25,
  parameter int T_DH_NS = 5,
  parameter int T_RC_NS = 55,
  parameter int T_AC_NS = 55,
  parameter int T_HZ_NS = 35
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_din
);

  localparam int AS_C = ns_to_cyc(T_AS_NS, CLK_NS);
  localparam int AH_C = ns_to_cyc(T_AH_NS, CLK_NS);
  localparam int CW_C = ns_to_cyc(T_CW_NS, CLK_NS);
  localparam int WC_C = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int DS_C = ns_to_cyc(T_DS_NS, CLK_NS);
  localparam int DH_C = ns_to_cyc(T_DH_NS, CLK_NS);
  localparam int RC_C = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int AC_C = ns_to_cyc(T_AC_NS, CLK_NS);
  localparam int HZ_C = ns_to_cyc(T_HZ_NS, CLK_NS);

  // data is driven from setup onward, so strobe covers the rest of data setup
  localparam int WSTR_C  = imax(CW_C, DS_C - AS_C);
  localparam int WHOLD_C = imax(imax(AH_C, DH_C), imax(WC_C - AS_C - WSTR_C, 1));
  localparam int RSTR_C  = AC_C;
  localparam int RTURN_C = imax(HZ_C, imax(RC_C - AS_C - RSTR_C, 1));
  localparam int MAX_C   = imax(imax(AS_C, WSTR_C), imax(WHOLD_C, imax(RSTR_C, RTURN_C)));
  localparam int CNT_W   = $clog2(MAX_C + 1);

  strobe_st_t       st_nxt;
  logic             op_nxt;
  logic             accept;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             done;
  logic             finish;
  logic             sample;

  strobe_tick #(
    .CNT_W(CNT_W)
  ) u_tick (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .done     (done)
  );

  strobe_seq #(
    .CNT_W   (CNT_W),
    .AS_C    (AS_C),
    .WSTR_C  (WSTR_C),
    .WHOLD_C (WHOLD_C),
    .RSTR_C  (RSTR_C),
    .RTURN_C (RTURN_C)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .req_wr   (req_wr),
    .done     (done),
    .st_nxt   (st_nxt),
    .op_nxt   (op_nxt),
    .accept   (accept),
    .load     (load),
    .load_val (load_val),
    .finish   (finish),
    .sample   (sample)
  );

  strobe_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk       (clk),
    .rst       (rst),
    .st_nxt    (st_nxt),
    .op_nxt    (op_nxt),
    .accept    (accept),
    .finish    (finish),
    .sample    (sample),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_din   (mem_din),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_dout  (mem_dout),
    .mem_dq_oe (mem_dq_oe),
    .ack       (ack),
    .rdata     (rdata)
  );

endmodule

// File: rtl/sram_strobe_chk.sv
module sram_strobe_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic [DATA_W-1:0] mem_dout,
  input logic              mem_dq_oe
);

  AST_WE_LEADS_CE: assert property (@(posedge clk) disable iff (rst)
    ($fell(mem_ce_n) && !mem_we_n) |-> $past(!mem_we_n)); // R2
  AST_WE_TRAILS_CE: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_ce_n) && $past(!mem_we_n)) |-> !mem_we_n); // R2
  AST_ADDR_STEADY_LOW: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> $stable(mem_addr)); // R3
  AST_ADDR_HOLD_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_ce_n) |-> $stable(mem_addr)); // R3
  AST_DOUT_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !mem_we_n) |-> $stable(mem_dout)); // R4
  AST_DOUT_HOLD_RISE: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_ce_n) && !mem_we_n) |-> $stable(mem_dout)); // R4
  AST_NO_DRIVE_READ: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && mem_we_n) |-> !mem_dq_oe); // R6
  AST_DRIVE_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> !mem_we_n); // R6
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R7

endmodule

bind sram_strobe_ctrl sram_strobe_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ack       (ack),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_dout  (mem_dout),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_sram_strobe_ctrl.sv
module sim_sram_strobe_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int W_LAT      = 6;   // R7
  localparam int R_LAT      = 11;  // R7
  localparam int CW_CYC     = 4;   // R3
  localparam int AC_CYC     = 6;   // R5
  localparam int HZ_CYC     = 4;   // R6

  logic        clk = 1'b0;
  logic        rst;
  logic        req, req_wr, req_wdata;
  logic [15:0] req_addr;
  logic        ack, rdata;
  logic [15:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_dout, mem_dq_oe;
  logic        mem_din = 1'b0;

  sram_strobe_ctrl u0 (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_dout(mem_dout),
    .mem_dq_oe(mem_dq_oe), .mem_din(mem_din)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { bit wr; logic [15:0] a; bit d; } exp_t;
  exp_t exp_q[$];
  bit   shadow [logic [15:0]];
  bit   mem_m  [logic [15:0]];
  int   n_chk = 0;
  int   n_fail = 0;
  int   pcnt = 0;
  longint cyc = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
    end
  endtask

  function automatic bit mem_get(input logic [15:0] a);
    return mem_m.exists(a) ? mem_m[a] : 1'b0;
  endfunction

  function automatic bit shadow_get(input logic [15:0] a);
    return shadow.exists(a) ? shadow[a] : 1'b0;
  endfunction

  // memory model: writes land while both strobes are low
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) pcnt <= 0;
    else if (!mem_ce_n) pcnt <= pcnt + 1;
    else pcnt <= 0;
    if (!rst && !mem_ce_n && !mem_we_n) mem_m[mem_addr] = mem_dout;
  end

  // read data is wrong until the access time has elapsed (R5)
  always @(negedge clk) begin
    if (!mem_ce_n && mem_we_n)
      mem_din <= (pcnt >= AC_CYC - 1) ? mem_get(mem_addr) : ~mem_get(mem_addr);
    else
      mem_din <= 1'b0;
  end

  // monitor: scoreboard and pin protocol
  logic        prev_ce = 1'b1, prev_we = 1'b1, prev_oe = 1'b0, prev_ack = 1'b0, prev_dout = 1'b0;
  int          lowlen = 0;
  int          since_rd = 1000;
  bit          fall_wr = 1'b0;
  bit          rd_drive = 1'b0;
  logic [15:0] fall_addr = '0;
  logic        fall_dout = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (ack) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected ack", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.wr) check(mem_get(e.a) == e.d, "R2", "memory after write", mem_get(e.a), e.d);
          else      check(rdata == e.d, "R5", "read data", rdata, e.d);
        end
        check(!prev_ack, "R7", "ack width", prev_ack, 0);
      end
      if (!mem_ce_n && mem_we_n && mem_dq_oe) rd_drive = 1'b1;
      if (prev_ce && !mem_ce_n) begin
        lowlen    = 1;
        fall_wr   = !mem_we_n;
        fall_addr = mem_addr;
        fall_dout = mem_dout;
        rd_drive  = 1'b0;
        if (!mem_we_n) begin
          check(!prev_we && mem_dq_oe, "R2", "we/oe before ce fall", prev_we, 0);
          check(prev_dout == mem_dout, "R4", "data setup", mem_dout, prev_dout);
        end
      end else if (!mem_ce_n) begin
        lowlen++;
      end
      if (!prev_ce && mem_ce_n) begin
        if (fall_wr) begin
          check(lowlen >= CW_CYC, "R3", "write ce low cycles", lowlen, CW_CYC);
          check(!mem_we_n && mem_dq_oe, "R2", "we/oe after ce rise", mem_we_n, 0);
          check(mem_addr == fall_addr, "R3", "address hold", mem_addr, fall_addr);
          check(mem_dout == fall_dout, "R4", "data hold", mem_dout, fall_dout);
        end else begin
          check(lowlen == AC_CYC, "R5", "read ce low cycles", lowlen, AC_CYC);
          check(!rd_drive, "R6", "driver during read", rd_drive, 0);
          since_rd = 0;
        end
      end else if (mem_ce_n && since_rd < 1000) begin
        since_rd++;
      end
      if (mem_dq_oe && !prev_oe)
        check(since_rd >= HZ_CYC, "R6", "turnaround before drive", since_rd, HZ_CYC);
    end
    prev_ce   = mem_ce_n;
    prev_we   = mem_we_n;
    prev_oe   = mem_dq_oe;
    prev_ack  = ack;
    prev_dout = mem_dout;
  end

  // driver: called at a falling edge while the controller is idle
  task automatic do_op(input bit wr, input logic [15:0] a, input bit d, input bit inject);
    exp_t e;
    int   n;
    int   lat;
    e.wr = wr; e.a = a; e.d = wr ? d : shadow_get(a);
    exp_q.push_back(e);
    if (wr) shadow[a] = d;
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    n = 1;
    if (inject) begin
      // R8: a write pulse while busy must be dropped
      @(negedge clk); n++;
      req = 1'b1; req_wr = 1'b1; req_addr = a ^ 16'h00FF; req_wdata = 1'b1;
      @(negedge clk); n++;
      req = 1'b0;
    end
    while (ack !== 1'b1 && n < 40) begin
      @(negedge clk);
      n++;
    end
    lat = wr ? W_LAT : R_LAT;
    check((n - 1) == lat, "R7", "ack latency", n - 1, lat);
  endtask

  bit finished = 1'b0;

  initial begin
    rst = 1'b1; req = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mem_ce_n && mem_we_n, "R1", "strobes high in reset", {mem_ce_n, mem_we_n}, 3);
    check(!mem_dq_oe && !ack, "R1", "driver off, no ack", {mem_dq_oe, ack}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(mem_ce_n && mem_we_n && !mem_dq_oe && !ack, "R1", "idle after reset",
          {mem_ce_n, mem_we_n, mem_dq_oe, ack}, 12);

    do_op(1'b1, 16'h0001, 1'b1, 1'b0);
    do_op(1'b0, 16'h0001, 1'b0, 1'b0);
    do_op(1'b1, 16'hFFFF, 1'b1, 1'b0);
    do_op(1'b1, 16'h0000, 1'b0, 1'b0);
    do_op(1'b0, 16'hFFFF, 1'b0, 1'b0);
    do_op(1'b0, 16'h0000, 1'b0, 1'b0);
    do_op(1'b0, 16'h1234, 1'b0, 1'b0);
    do_op(1'b1, 16'h0001, 1'b0, 1'b0);
    do_op(1'b0, 16'h0001, 1'b0, 1'b0);

    // R8: busy request ignored, target stays unwritten
    do_op(1'b1, 16'h00AA, 1'b1, 1'b1);
    repeat (15) @(negedge clk);
    do_op(1'b0, 16'h0055, 1'b0, 1'b0);
    do_op(1'b0, 16'h00AA, 1'b0, 1'b0);

    // R9: back-to-back, each request raised in the previous ack cycle
    begin
      longint t0;
      longint expect_cyc;
      logic [15:0] a;
      t0 = cyc;
      expect_cyc = 0;
      a = 16'hACE1;
      for (int i = 0; i < 10; i++) begin
        a = {a[14:0], a[15] ^ a[13] ^ a[12] ^ a[10]};
        if (i % 2 == 0) begin
          do_op(1'b1, a, a[0], 1'b0);
          expect_cyc += W_LAT + 1;
        end else begin
          do_op(1'b0, {a[15:1], 1'b0} ^ 16'h0, 1'b0, 1'b0);
          expect_cyc += R_LAT + 1;
        end
      end
      check((cyc - t0) == expect_cyc, "R9", "back-to-back cycles", cyc - t0, expect_cyc);
    end

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R7", "outstanding acks", exp_q.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule